// File: doc/BRIEF.md
# Cascaded 32-bit Time Base

This block builds a free-running 32-bit time base out of two 16-bit counter channels. The lower channel counts ticks of a prescaled system clock. It also drives a square wave from two compare points: the wave goes high when the count reaches zero and goes low when the count reaches half scale. The upper channel counts the rising edges of that wave, after a two-stage synchroniser. As a result, the upper half advances once per full turn of the lower half.

Software starts the counters with an enable command and freezes them with a disable command. A block-wide sync command clears every counter at once. Each channel's count is read through a small select-and-read port. To get a coherent 32-bit value, software reads upper, then lower, then upper again, and retries if the two upper samples differ.

A build-time parameter selects a second configuration. In it, channel 0 is a single 32-bit counter and channel 1 does not exist.

Top module: `casc_timebase`

## Requirements
- R1: After reset, both channel counts read 0 and `wave_o` is 0.
- R2: While running, channel 0 advances by one on each prescaled tick. `clk_sel_i` code k divides by 4^k, giving 1, 4, 16 or 64. A tick occurs on the cycle in which the low 2k bits of a free-running prescale counter are all ones. Sync clears that counter to zero, so with code k the first increment lands 4^k cycles after the sync edge.
- R3: An enable pulse lets counting begin from the edge after the one that samples it. A disable pulse freezes the count without clearing it. When both arrive in the same cycle, disable wins.
- R4: One cycle after channel 0 steps to 0x0000, `wave_o` goes high. One cycle after channel 0 steps to 0x8000, `wave_o` goes low. Sync forces `wave_o` low.
- R5: Channel 1 increments four cycles after channel 0 wraps to zero. That is one cycle after `wave_o` rises plus three synchroniser and edge-detect stages. This gives exactly one upper count per 65536 lower counts.
- R6: A sync pulse clears both counts, the wave, the prescaler and the edge detector on the next edge. The run state is left unchanged.
- R7: With `rd_sel_i`=0, `rd_data_o` returns channel 0 zero-extended. With `rd_sel_i`=1, it returns channel 1 zero-extended.
- R8: With `WIDE`=1, channel 0 is a 32-bit counter read at `rd_sel_i`=0, and `rd_sel_i`=1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 2 | Prescale select, divide by 4^code |
| clk_en_i | input | 1 | Enable command pulse |
| clk_dis_i | input | 1 | Disable command pulse |
| sync_i | input | 1 | Block-wide counter clear pulse |
| rd_sel_i | input | 1 | Read select: 0 lower channel, 1 upper channel |
| rd_data_o | output | 32 | Selected channel count |
| wave_o | output | 1 | Channel 0 compare waveform |

## Verification
Three kinds of internal fault show at the ports:

- **Prescaler phase or run-gating fault.** The lower count is off at a fixed cycle after sync, so a read ten ticks later already shows the error.
- **Compare or wave fault.** A compare that sets or clears the wave at the wrong point, or a missing wave clear on sync, moves the upper increment away from cycle 65540 after sync. It appears at the half-scale or wrap point.
- **Synchroniser depth fault.** A wrong number of synchroniser stages shifts the upper step by whole cycles, which the checks one cycle on either side of it catch.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
  localparam int SEL_W = 2;
  // prescale counter wide enough for the largest divisor 4^(2^SEL_W-1)
  localparam int PRE_W = 2 * ((1 << SEL_W) - 1);
  typedef enum logic [SEL_W-1:0] {DIV1 = 2'd0, DIV4 = 2'd1, DIV16 = 2'd2, DIV64 = 2'd3} div_sel_e;
endpackage

// File: rtl/ctb_prescale.sv
module ctb_prescale
  import ctb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < 2 * int'(sel_i));
  end

  assign tick_o = (pre_q & mask) == mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (sync_i) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R6
  pre_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> pre_q == '0);
endmodule

// File: rtl/ctb_count.sv
module ctb_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  logic         run_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         stepped_o
);
  logic [W-1:0] cnt_q;
  logic         stepped_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      stepped_q <= 1'b0;
    end else if (sync_i) begin
      cnt_q     <= '0;
      stepped_q <= 1'b0;
    end else begin
      stepped_q <= run_i & step_i;
      if (run_i && step_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign stepped_o = stepped_q;

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !sync_i) |=> $stable(cnt_q));
  // R2
  inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && step_i && !sync_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  // R6
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == '0 && !stepped_q));
endmodule

// File: rtl/ctb_wavegen.sv
module ctb_wavegen #(
  parameter int          W       = 16,
  parameter int unsigned SET_AT  = 0,
  parameter int unsigned CLR_AT  = 32'h8000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sync_i,
  input  logic         stepped_i,
  input  logic [W-1:0] cnt_i,
  output logic         wave_o
);
  localparam logic [W-1:0] SET_V = W'(SET_AT);
  localparam logic [W-1:0] CLR_V = W'(CLR_AT);

  logic wave_q;

  // compare only on a fresh count, so a sync to zero does not raise the wave
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wave_q <= 1'b0;
    else if (sync_i)                      wave_q <= 1'b0;
    else if (stepped_i && cnt_i == CLR_V) wave_q <= 1'b0;
    else if (stepped_i && cnt_i == SET_V) wave_q <= 1'b1;
  end

  assign wave_o = wave_q;

  // R4
  wave_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> !wave_q);
  // R4
  wave_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stepped_i && !sync_i) |=> $stable(wave_q));
endmodule

// File: rtl/ctb_edge_sync.sv
module ctb_edge_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic async_i,
  output logic rise_o
);
  logic [2:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '0;
    else if (sync_i) s_q <= '0;
    else             s_q <= {s_q[1:0], async_i};
  end

  assign rise_o = s_q[1] & ~s_q[2];

  // R5
  rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/casc_timebase.sv
module casc_timebase
  import ctb_pkg::*;
#(
  parameter int          CH_W   = 16,
  parameter bit          WIDE   = 1'b0,
  parameter int unsigned SET_AT = 0,
  parameter int unsigned CLR_AT = 32'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  clk_sel_i,
  input  logic              clk_en_i,
  input  logic              clk_dis_i,
  input  logic              sync_i,
  input  logic              rd_sel_i,
  output logic [2*CH_W-1:0] rd_data_o,
  output logic              wave_o
);
  localparam int RD_W = 2 * CH_W;
  localparam int C0_W = WIDE ? RD_W : CH_W;

  logic            run_q;
  logic            tick;
  logic [C0_W-1:0] c0_cnt;
  logic            c0_stepped;
  logic [CH_W-1:0] c1_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 1'b0;
    else if (clk_dis_i) run_q <= 1'b0;
    else if (clk_en_i)  run_q <= 1'b1;
  end

  ctb_prescale u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .sel_i (clk_sel_i), .tick_o(tick)
  );

  ctb_count #(.W(C0_W)) u_ch0 (
    .clk_i (clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .run_i(run_q),
    .step_i(tick), .cnt_o(c0_cnt), .stepped_o(c0_stepped)
  );

  ctb_wavegen #(.W(C0_W), .SET_AT(SET_AT), .CLR_AT(CLR_AT)) u_wave (
    .clk_i (clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .stepped_i(c0_stepped), .cnt_i(c0_cnt), .wave_o(wave_o)
  );

  generate
    if (WIDE) begin : g_single
      assign c1_cnt = '0;
    end else begin : g_cascade
      logic rise;
      logic c1_stepped;

      ctb_edge_sync u_edge (
        .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
        .async_i(wave_o), .rise_o(rise)
      );

      ctb_count #(.W(CH_W)) u_ch1 (
        .clk_i (clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .run_i(run_q),
        .step_i(rise), .cnt_o(c1_cnt), .stepped_o(c1_stepped)
      );

      // R5
      c1_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        c1_stepped |-> $past(rise));
      // R7
      rd_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_sel_i |-> rd_data_o[RD_W-1:CH_W] == '0);
    end
  endgenerate

  assign rd_data_o = rd_sel_i ? RD_W'(c1_cnt) : RD_W'(c0_cnt);

  // R3
  dis_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_dis_i |=> !run_q);
endmodule

// File: tb/casc_timebase_tb_top.sv
`timescale 1ns/100ps
module casc_timebase_tb_top;
  import ctb_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  clk_sel_i = DIV1;
  logic        clk_en_i = 1'b0;
  logic        clk_dis_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        rd_sel_i = 1'b0;
  logic [31:0] rd_data_o, rd_data_w;
  logic        wave_o, wave_w;

  int n_chk = 0;
  int n_bad = 0;
  int since = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  casc_timebase dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_sel_i(clk_sel_i), .clk_en_i(clk_en_i),
    .clk_dis_i(clk_dis_i), .sync_i(sync_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .wave_o(wave_o)
  );

  casc_timebase #(.WIDE(1'b1)) dut_w_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_sel_i(clk_sel_i), .clk_en_i(clk_en_i),
    .clk_dis_i(clk_dis_i), .sync_i(sync_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_w), .wave_o(wave_w)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [31:0] v, output logic [31:0] vw);
    rd_sel_i = s;
    #0.2;
    v  = rd_data_o;
    vw = rd_data_w;
  endtask

  // issue commands on one edge; that edge becomes time zero
  task automatic cmd(input bit s, input bit e, input bit d);
    @(negedge clk_i);
    sync_i = s; clk_en_i = e; clk_dis_i = d;
    @(posedge clk_i);
    since = 0;
    #0.5;
    sync_i = 1'b0; clk_en_i = 1'b0; clk_dis_i = 1'b0;
  endtask

  task automatic goto(input int t);
    repeat (t - since) @(posedge clk_i);
    since = t;
    #0.5;
  endtask

  task automatic t_reset();
    logic [31:0] v, vw;
    #10;
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #0.5;
    rd(1'b0, v, vw); chk("R1 lower", v, 32'h0);
    rd(1'b1, v, vw); chk("R1 upper", v, 32'h0);
    chk("R1 wave", {31'b0, wave_o}, 32'h0);
  endtask

  task automatic t_rate(input logic [1:0] sel, input int per);
    logic [31:0] v, vw;
    clk_sel_i = sel;
    cmd(1'b1, 1'b1, 1'b0);
    goto(per * 10 - 1);
    rd(1'b0, v, vw); chk($sformatf("R2 div%0d before tick", per), v, 32'd9);
    goto(per * 10);
    rd(1'b0, v, vw); chk($sformatf("R2 div%0d on tick", per), v, 32'd10);
  endtask

  task automatic t_gate();
    logic [31:0] v, vw;
    clk_sel_i = DIV1;
    cmd(1'b1, 1'b1, 1'b0);
    cmd(1'b0, 1'b0, 1'b1);
    rd(1'b0, v, vw); chk("R3 last step on disable edge", v, 32'd1);
    goto(20);
    rd(1'b0, v, vw); chk("R3 frozen not cleared", v, 32'd1);
    cmd(1'b0, 1'b1, 1'b1);
    goto(10);
    rd(1'b0, v, vw); chk("R3 disable wins", v, 32'd1);
    cmd(1'b0, 1'b1, 1'b0);
    rd(1'b0, v, vw); chk("R3 no step on enable edge", v, 32'd1);
    goto(5);
    rd(1'b0, v, vw); chk("R3 resumes", v, 32'd6);
  endtask

  task automatic t_long();
    logic [31:0] v, vw, h0, h1;
    clk_sel_i = DIV1;
    cmd(1'b1, 1'b1, 1'b0);
    goto(32768);
    rd(1'b0, v, vw); chk("R2 lower half scale", v, 32'h8000);
    chk("R4 wave low after sync", {31'b0, wave_o}, 32'h0);
    goto(65535);
    rd(1'b0, v, vw); chk("R7 lower full", v, 32'hffff);
    rd(1'b1, v, vw); chk("R5 upper before wrap", v, 32'h0);
    goto(65536);
    rd(1'b0, v, vw); chk("R2 lower wraps", v, 32'h0);
    chk("R8 wide no wrap", vw, 32'h10000);
    chk("R4 wave not yet", {31'b0, wave_o}, 32'h0);
    goto(65537);
    chk("R4 wave rises", {31'b0, wave_o}, 32'h1);
    goto(65539);
    rd(1'b1, v, vw); chk("R5 upper not early", v, 32'h0);
    goto(65540);
    rd(1'b1, h0, vw); chk("R5 upper steps", h0, 32'h1);
    chk("R8 wide upper reads zero", vw, 32'h0);
    rd(1'b0, v, vw); chk("R7 lower after wrap", v, 32'h4);
    chk("R8 wide 32-bit count", vw, 32'h10004);
    rd(1'b1, h1, vw); chk("R7 upper reread stable", h1, h0);
    chk("R7 combined value", (h0 << 16) | v, 32'h10004);
    goto(98304);
    chk("R4 wave high before half", {31'b0, wave_o}, 32'h1);
    goto(98305);
    chk("R4 wave falls", {31'b0, wave_o}, 32'h0);
  endtask

  task automatic t_sync();
    logic [31:0] v, vw;
    goto(98400);
    cmd(1'b1, 1'b0, 1'b0);
    rd(1'b0, v, vw); chk("R6 lower cleared", v, 32'h0);
    chk("R6 wide cleared", vw, 32'h0);
    rd(1'b1, v, vw); chk("R6 upper cleared", v, 32'h0);
    chk("R6 wave cleared", {31'b0, wave_o}, 32'h0);
    goto(3);
    rd(1'b0, v, vw); chk("R6 keeps running", v, 32'd3);
    goto(8);
    rd(1'b1, v, vw); chk("R6 no spurious upper", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_rate(DIV1, 1);
    t_rate(DIV4, 4);
    t_rate(DIV16, 16);
    t_rate(DIV64, 64);
    t_gate();
    t_long();
    t_sync();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule